// File: doc/BRIEF.md
# Link Latency Measurement Monitor

This block watches a deterministic-latency serial receiver during link bring-up and measures, in link clock cycles, how long the receiver takes from the moment the synchronization request is released until it first presents valid user data. The request line is active low. Counting begins on the cycle in which it is first sampled high after being low. Counting ends on the first cycle in which the receiver's link-valid signal is sampled high. The measured count is held on an output together with a done flag. Pulling the request line low again rearms the monitor for the next bring-up.

For a link to count as deterministic, every reset and every power cycle must yield the same latency. Word alignment can still shift the result by a cycle or two. The monitor therefore keeps the first completed measurement as a reference. Each later result is compared with that reference against a tolerance that the user sets. The result of the latest comparison is shown on an output, and a sticky flag records any comparison that has ever failed. The smallest and largest counts seen so far are also kept, so that a test rig can report the spread after many link restarts.

Top module: `link_latency_monitor`

## Requirements
- R1: While `rstN` is low and just after it rises, `measDone`, `refValid`, `withinTol` and `mismatchSticky` are 0, and `latCount`, `refCount`, `minCount` and `maxCount` are 0.
- R2: Call E0 the clock edge at which `syncN` is first sampled 1 after having been sampled 0. If `linkValid` is first sampled 1 at edge E0+k, then after that edge `latCount` equals k and `measDone` is 1.
- R3: `linkValid` has no effect while `syncN` is low. While `measDone` is 1 and `syncN` stays high, further `linkValid` activity leaves `latCount` unchanged.
- R4: If `syncN` is sampled 0 before a measurement completes, the run is abandoned. The next rise of `syncN` starts a new count from zero.
- R5: If `syncN` is sampled 0 while `measDone` is 1, `measDone` is 0 after that edge, and `latCount` keeps the last result.
- R6: The count saturates at 2^CNT_W-1 (65535 by default) and never wraps.
- R7: The first completed measurement after reset is loaded into `refCount`, `refValid` becomes 1, and `withinTol` is 1. After that, `refCount` does not change until reset.
- R8: For each later measurement M, `withinTol` becomes 1 when |M-`refCount`| <= `tolerance` and 0 otherwise. A result outside the tolerance sets `mismatchSticky`, which stays at 1 until reset.
- R9: `minCount` and `maxCount` hold the smallest and largest completed measurements since reset.
- R10: If `linkValid` is already 1 at edge E0, the measurement is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncN | input | 1 | Synchronization request, active low |
| linkValid | input | 1 | Receiver link-valid, high once user data flows |
| tolerance | input | TOL_W | Allowed deviation from the reference, in cycles |
| latCount | output | CNT_W | Last measured latency |
| measDone | output | 1 | A measurement has completed since the last request |
| refValid | output | 1 | A reference has been stored |
| refCount | output | CNT_W | Reference latency (first measurement) |
| withinTol | output | 1 | Last measurement lies within tolerance of the reference |
| mismatchSticky | output | 1 | Some measurement has fallen outside the tolerance |
| minCount | output | CNT_W | Smallest measurement seen |
| maxCount | output | CNT_W | Largest measurement seen |

## Verification
All results register on the same edge that samples the first high `linkValid`, which is edge E0+k. The clear of `measDone` is due one edge after `syncN` is sampled low. The bench drives every input on the falling edge. For each run it counts k falling edges after releasing `syncN` before it raises `linkValid`, and it reads all outputs on the next falling edge, so every sample lands half a cycle after the edge that is due to update it. A reference model in the bench computes the expected comparison, sticky flag, minimum and maximum from the requirements.

// File: rtl/latmon_pkg.sv
package latmon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;  // load counter with zero (run start)
    logic cntInc;    // saturating increment
    logic capture;   // latch result and update statistics
  } latStrobe_t;

endpackage

// File: rtl/latmon_ctrl.sv
module latmon_ctrl
  import latmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncN,
  input  logic       linkValid,
  output latStrobe_t strobe,
  output logic       measDone
);

  ctlState_t state, stateNext;
  logic      syncPrev;
  logic      syncRise;

  // syncPrev resets high: a link already up at reset does not start a run
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev <= 1'b1;
      state    <= ST_IDLE;
    end else begin
      syncPrev <= syncN;
      state    <= stateNext;
    end
  end

  assign syncRise = syncN & ~syncPrev;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (syncRise) begin
          strobe.cntClear = 1'b1;
          if (linkValid) begin
            strobe.capture = 1'b1;
            stateNext      = ST_DONE;
          end else begin
            stateNext      = ST_COUNT;
          end
        end
      end
      ST_COUNT: begin
        if (!syncN) begin
          stateNext = ST_IDLE;
        end else begin
          strobe.cntInc = 1'b1;
          if (linkValid) begin
            strobe.capture = 1'b1;
            stateNext      = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        if (!syncN) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign measDone = (state == ST_DONE);

endmodule

// File: rtl/latmon_count.sv
module latmon_count
  import latmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  latStrobe_t       strobe,
  output logic [CNT_W-1:0] capVal,
  output logic [CNT_W-1:0] latCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] satInc;

  assign satInc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  assign capVal = strobe.cntClear ? '0 : satInc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      latCount <= '0;
    end else begin
      if (strobe.cntClear)    cnt <= '0;
      else if (strobe.cntInc) cnt <= satInc;
      if (strobe.capture)     latCount <= capVal;
    end
  end

endmodule

// File: rtl/latmon_stats.sv
module latmon_stats #(
  parameter int CNT_W = 16,
  parameter int TOL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capture,
  input  logic [CNT_W-1:0] capVal,
  input  logic [TOL_W-1:0] tolerance,
  output logic             refValid,
  output logic [CNT_W-1:0] refCount,
  output logic             withinTol,
  output logic             mismatchSticky,
  output logic [CNT_W-1:0] minCount,
  output logic [CNT_W-1:0] maxCount
);

  localparam int CMP_W = (CNT_W > TOL_W) ? CNT_W : TOL_W;

  logic [CNT_W-1:0] absDiff;
  logic [CMP_W-1:0] diffExt;
  logic [CMP_W-1:0] tolExt;
  logic             inRange;

  assign absDiff = (capVal >= refCount) ? capVal - refCount : refCount - capVal;
  assign diffExt = CMP_W'(absDiff);
  assign tolExt  = CMP_W'(tolerance);
  assign inRange = (diffExt <= tolExt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refValid       <= 1'b0;
      refCount       <= '0;
      withinTol      <= 1'b0;
      mismatchSticky <= 1'b0;
      minCount       <= '0;
      maxCount       <= '0;
    end else if (capture) begin
      if (!refValid) begin
        refValid  <= 1'b1;
        refCount  <= capVal;
        withinTol <= 1'b1;
        minCount  <= capVal;
        maxCount  <= capVal;
      end else begin
        withinTol <= inRange;
        if (!inRange)            mismatchSticky <= 1'b1;
        if (capVal < minCount)   minCount <= capVal;
        if (capVal > maxCount)   maxCount <= capVal;
      end
    end
  end

endmodule

// File: rtl/link_latency_monitor.sv
module link_latency_monitor
  import latmon_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TOL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncN,
  input  logic             linkValid,
  input  logic [TOL_W-1:0] tolerance,
  output logic [CNT_W-1:0] latCount,
  output logic             measDone,
  output logic             refValid,
  output logic [CNT_W-1:0] refCount,
  output logic             withinTol,
  output logic             mismatchSticky,
  output logic [CNT_W-1:0] minCount,
  output logic [CNT_W-1:0] maxCount
);

  latStrobe_t       strobe;
  logic [CNT_W-1:0] capVal;

  latmon_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .syncN     (syncN),
    .linkValid (linkValid),
    .strobe    (strobe),
    .measDone  (measDone)
  );

  latmon_count #(.CNT_W(CNT_W)) uCount (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .capVal   (capVal),
    .latCount (latCount)
  );

  latmon_stats #(.CNT_W(CNT_W), .TOL_W(TOL_W)) uStats (
    .clk            (clk),
    .rstN           (rstN),
    .capture        (strobe.capture),
    .capVal         (capVal),
    .tolerance      (tolerance),
    .refValid       (refValid),
    .refCount       (refCount),
    .withinTol      (withinTol),
    .mismatchSticky (mismatchSticky),
    .minCount       (minCount),
    .maxCount       (maxCount)
  );

endmodule

// File: rtl/link_latency_monitor_chk.sv
module link_latency_monitor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             syncN,
  input logic [CNT_W-1:0] latCount,
  input logic             measDone,
  input logic             refValid,
  input logic [CNT_W-1:0] refCount,
  input logic             withinTol,
  input logic             mismatchSticky,
  input logic [CNT_W-1:0] minCount,
  input logic [CNT_W-1:0] maxCount
);

  AST_DONE_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (measDone && syncN) |=> (measDone && $stable(latCount))); // R3

  AST_REQUEST_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !syncN |=> !measDone); // R5

  AST_DONE_HAS_REFERENCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(measDone) |-> refValid); // R7

  AST_REFERENCE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    refValid |=> (refValid && $stable(refCount))); // R7

  AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    mismatchSticky |=> mismatchSticky); // R8

  AST_OUT_OF_TOL_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && !withinTol) |-> mismatchSticky); // R8

  AST_RANGE_ORDERED: assert property (@(posedge clk) disable iff (!rstN)
    refValid |-> (minCount <= refCount && refCount <= maxCount &&
                  minCount <= latCount && latCount <= maxCount)); // R9

endmodule

bind link_latency_monitor link_latency_monitor_chk #(.CNT_W(CNT_W)) uChk (
  .clk            (clk),
  .rstN           (rstN),
  .syncN          (syncN),
  .latCount       (latCount),
  .measDone       (measDone),
  .refValid       (refValid),
  .refCount       (refCount),
  .withinTol      (withinTol),
  .mismatchSticky (mismatchSticky),
  .minCount       (minCount),
  .maxCount       (maxCount)
);

// File: tb/tb_link_latency_monitor.sv
module tb_link_latency_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int TOL_W = 4;
  localparam int SAT_VAL = (1 << CNT_W) - 1;

  // table: latency k, tolerance, expected withinTol (reference is first entry)
  localparam int VEC_N = 7;
  localparam int VK[VEC_N] = '{60, 61, 62, 63, 58, 75, 57};
  localparam int VT[VEC_N] = '{ 2,  2,  2,  2,  2, 10,  1};
  localparam int VW[VEC_N] = '{ 1,  1,  1,  0,  1,  0,  0};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             syncN = 1'b0;
  logic             linkValid = 1'b0;
  logic [TOL_W-1:0] tolerance = '0;
  logic [CNT_W-1:0] latCount, refCount, minCount, maxCount;
  logic             measDone, refValid, withinTol, mismatchSticky;

  int nChecks = 0;
  int nFails  = 0;

  // bench model of the statistics
  int  mRefValid, mRef, mMin, mMax, mMis;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_latency_monitor #(.CNT_W(CNT_W), .TOL_W(TOL_W)) dut (
    .clk(clk), .rstN(rstN), .syncN(syncN), .linkValid(linkValid),
    .tolerance(tolerance), .latCount(latCount), .measDone(measDone),
    .refValid(refValid), .refCount(refCount), .withinTol(withinTol),
    .mismatchSticky(mismatchSticky), .minCount(minCount), .maxCount(maxCount)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; syncN = 1'b0; linkValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mRefValid = 0; mRef = 0; mMin = 0; mMax = 0; mMis = 0;
  endtask

  // release syncN, raise linkValid so it is first sampled at E0+k,
  // return at the falling edge after E0+k
  task automatic runMeas(input int k);
    @(negedge clk); syncN = 1'b0; linkValid = 1'b0;
    repeat (3) @(negedge clk);
    syncN = 1'b1;
    if (k == 0) linkValid = 1'b1;
    else begin
      repeat (k) @(negedge clk);
      linkValid = 1'b1;
    end
    @(negedge clk);
    linkValid = 1'b0;
  endtask

  task automatic modelUpdate(input int m, input int tol);
    int d;
    if (mRefValid == 0) begin
      mRefValid = 1; mRef = m; mMin = m; mMax = m;
    end else begin
      d = (m >= mRef) ? m - mRef : mRef - m;
      if (d > tol) mMis = 1;
      if (m < mMin) mMin = m;
      if (m > mMax) mMax = m;
    end
  endtask

  task automatic checkStats(input string tag);
    check("R7", {tag, " refValid"}, int'(refValid), mRefValid);
    check("R7", {tag, " refCount"}, int'(refCount), mRef);
    check("R8", {tag, " mismatchSticky"}, int'(mismatchSticky), mMis);
    check("R9", {tag, " minCount"}, int'(minCount), mMin);
    check("R9", {tag, " maxCount"}, int'(maxCount), mMax);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL R2 watchdog expired: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    // R1 reset state
    doReset();
    @(negedge clk);
    check("R1", "measDone", int'(measDone), 0);
    check("R1", "latCount", int'(latCount), 0);
    check("R1", "refValid", int'(refValid), 0);
    check("R1", "withinTol", int'(withinTol), 0);
    check("R1", "mismatchSticky", int'(mismatchSticky), 0);
    check("R1", "minCount", int'(minCount), 0);
    check("R1", "maxCount", int'(maxCount), 0);

    // R3: linkValid while syncN low has no effect
    linkValid = 1'b1;
    repeat (5) @(negedge clk);
    linkValid = 1'b0;
    @(negedge clk);
    check("R3", "done while syncN low", int'(measDone), 0);

    // table walk: R2, R7, R8, R9
    for (int i = 0; i < VEC_N; i++) begin
      tolerance = TOL_W'(VT[i]);
      runMeas(VK[i]);
      modelUpdate(VK[i], VT[i]);
      check("R2", $sformatf("vec%0d latCount", i), int'(latCount), VK[i]);
      check("R2", $sformatf("vec%0d measDone", i), int'(measDone), 1);
      check("R8", $sformatf("vec%0d withinTol", i), int'(withinTol), VW[i]);
      checkStats($sformatf("vec%0d", i));
    end

    // R3: linkValid toggling after done leaves result unchanged
    repeat (4) begin
      @(negedge clk); linkValid = ~linkValid;
    end
    @(negedge clk); linkValid = 1'b0;
    @(negedge clk);
    check("R3", "latCount after done", int'(latCount), VK[VEC_N-1]);
    check("R3", "measDone held", int'(measDone), 1);

    // R5: request clears done, keeps result
    syncN = 1'b0;
    @(negedge clk);
    check("R5", "measDone cleared", int'(measDone), 0);
    check("R5", "latCount kept", int'(latCount), VK[VEC_N-1]);

    // R4: abandon a run, then a fresh one counts from zero
    doReset();
    tolerance = 4'd3;
    @(negedge clk); syncN = 1'b1;
    repeat (20) @(negedge clk);
    syncN = 1'b0;
    repeat (2) @(negedge clk);
    check("R4", "done after abandon", int'(measDone), 0);
    check("R4", "no reference after abandon", int'(refValid), 0);
    runMeas(70);
    modelUpdate(70, 3);
    check("R4", "fresh count", int'(latCount), 70);
    checkStats("R4 run");

    // R10: linkValid already high on the release edge
    doReset();
    runMeas(0);
    modelUpdate(0, 3);
    check("R10", "zero latency", int'(latCount), 0);
    check("R10", "measDone", int'(measDone), 1);
    runMeas(1);
    modelUpdate(1, 3);
    check("R10", "one cycle latency", int'(latCount), 1);

    // R6: saturation
    doReset();
    runMeas(SAT_VAL + 5);
    check("R6", "saturated count", int'(latCount), SAT_VAL);
    check("R6", "measDone", int'(measDone), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule